// File: doc/BRIEF.md
# Multi-Width Unsigned Divide Unit

A sequential unsigned integer divider for an execution stage. One request divides a double-width dividend by a single-width divisor at an operand width of 8, 16, 32 or 64 bits. It returns the truncated quotient and the remainder. When the divisor is zero, when the quotient would not fit in the operand width, or when the 64-bit width is requested outside 64-bit mode, it raises a divide-error flag in place of a result. On an error the result outputs keep the values they held before.

A request is taken on a clock edge where `start_i` is high and the unit is idle. Error cases resolve at that same edge. Legal requests run a shift-subtract loop that produces one quotient bit per cycle for exactly operand-width cycles. `done_o` then pulses for one cycle, with `err_o` qualifying it. For the byte width, the 16-bit destination word is `{rem_o[7:0], quot_o[7:0]}`: quotient low, remainder high. For the wider widths, the quotient and the remainder each fill one operand-width destination.

Top module: `mw_div`

## Requirements
- R1: `size_i` selects the operand width n: 0 for 8, 1 for 16, 2 for 32, 3 for 64. Only `dividend_i[2n-1:0]` and `divisor_i[n-1:0]` are used, and bits above them have no effect on any output.
- R2: On a successful divide, `quot_o[n-1:0]` holds floor(dividend/divisor) and `rem_o[n-1:0]` holds dividend mod divisor. Bits n and above of both outputs are zero.
- R3: A divisor of zero gives `done_o`=1 and `err_o`=1, and `quot_o`/`rem_o` keep their previous values.
- R4: A quotient above 2^n-1 (FFh, FFFFh, FFFFFFFFh, FFFFFFFFFFFFFFFFh) gives `done_o`=1 and `err_o`=1, with `quot_o`/`rem_o` unchanged. This occurs exactly when the upper n dividend bits are not below the divisor.
- R5: After a successful divide, `rem_o` is strictly less than the divisor.
- R6: `size_i`=3 while `mode64_i`=0 is rejected with `done_o`=1 and `err_o`=1.
- R7: `done_o` is high for a single cycle. For error cases it is visible after the accepting edge. For legal requests it is visible after n further edges.
- R8: `busy_o` is high from the accepting edge until the result edge. `start_i` is ignored while `busy_o` is high.
- R9: While `rst_ni` is low, `busy_o`, `done_o`, `err_o`, `quot_o` and `rem_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| size_i | input | 2 | Operand width select |
| mode64_i | input | 1 | Permits the 64-bit width |
| dividend_i | input | 128 | Double-width dividend |
| divisor_i | input | 64 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide error, valid with done_o |
| quot_o | output | 64 | Quotient, zero-extended |
| rem_o | output | 64 | Remainder, zero-extended |

## Verification
An error result is due at the first sample after the accepting edge. A legal result is due n edges after that, so 9, 17, 33 or 65 edges after the request in total. The bench counts edges from the request up to the `done_o` pulse and compares that count with the value for the selected width. It then requires `done_o` to be low one cycle later. Values are read only in the sample where `done_o` is seen. Busy status and ignored starts are probed one cycle after acceptance.

// File: rtl/mw_div_pkg.sv
package mw_div_pkg;
  localparam int NSIZE = 4;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2, SZ_Q = 2'd3} size_e;
endpackage

// File: rtl/mw_div_pre.sv
module mw_div_pre
  import mw_div_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CW   = $clog2(XLEN + 1)
) (
  input  size_e               size_i,
  input  logic                mode64_i,
  input  logic [2*XLEN-1:0]   dividend_i,
  input  logic [XLEN-1:0]     divisor_i,
  output logic [XLEN-1:0]     hi_o,
  output logic [XLEN-1:0]     lo_o,
  output logic [XLEN-1:0]     dv_o,
  output logic [CW-1:0]       steps_o,
  output logic                err_o
);
  logic [XLEN-1:0] hi_a [NSIZE];
  logic [XLEN-1:0] lo_a [NSIZE];
  logic [XLEN-1:0] dv_a [NSIZE];
  logic [CW-1:0]   st_a [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_sz
    localparam int N = XLEN >> (NSIZE - 1 - g);
    assign hi_a[g] = XLEN'(dividend_i[2*N-1:N]);
    // low half left-aligned so the core always shifts from the top bit
    assign lo_a[g] = XLEN'(dividend_i[N-1:0]) << (XLEN - N);
    assign dv_a[g] = XLEN'(divisor_i[N-1:0]);
    assign st_a[g] = CW'(N);
  end

  logic [1:0] sel;
  logic       illegal;
  assign sel     = size_i;
  assign hi_o    = hi_a[sel];
  assign lo_o    = lo_a[sel];
  assign dv_o    = dv_a[sel];
  assign steps_o = st_a[sel];
  assign illegal = (size_i == SZ_Q) && !mode64_i;
  // quotient fits iff upper half < divisor
  assign err_o   = illegal || (dv_o == '0) || (hi_o >= dv_o);
endmodule

// File: rtl/mw_div_core.sv
module mw_div_core #(
  parameter int XLEN = 64,
  parameter int CW   = $clog2(XLEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] dv_i,
  input  logic [CW-1:0]   steps_i,
  output logic            busy_o,
  output logic            last_o,
  output logic [XLEN-1:0] quo_nxt_o,
  output logic [XLEN-1:0] rem_nxt_o
);
  logic            busy_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN-1:0] rem_q, sh_q, quo_q, dv_q;
  logic [XLEN:0]   trial;
  logic [XLEN-1:0] diff;
  logic            ge;

  assign trial     = {rem_q, sh_q[XLEN-1]};
  assign ge        = trial >= {1'b0, dv_q};
  assign diff      = trial[XLEN-1:0] - dv_q;
  assign rem_nxt_o = ge ? diff : trial[XLEN-1:0];
  assign quo_nxt_o = {quo_q[XLEN-2:0], ge};
  assign last_o    = busy_q && (cnt_q == CW'(1));
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      sh_q   <= '0;
      quo_q  <= '0;
      dv_q   <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= steps_i;
      rem_q  <= hi_i;
      sh_q   <= lo_i;
      quo_q  <= '0;
      dv_q   <= dv_i;
    end else if (busy_q) begin
      rem_q <= rem_nxt_o;
      sh_q  <= sh_q << 1;
      quo_q <= quo_nxt_o;
      cnt_q <= cnt_q - CW'(1);
      if (last_o) busy_q <= 1'b0;
    end
  end

  // partial remainder stays below divisor through the loop
  p_rem_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < dv_q));
  p_cnt_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0));
endmodule

// File: rtl/mw_div.sv
module mw_div
  import mw_div_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CW  = $clog2(XLEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              mode64_i,
  input  logic [2*XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0]   divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [XLEN-1:0]   quot_o,
  output logic [XLEN-1:0]   rem_o
);
  logic [XLEN-1:0] hi, lo, dv, quo_nxt, rem_nxt;
  logic [CW-1:0]   steps;
  logic            pre_err, accept, last, busy;
  logic            done_q, err_q;
  logic [XLEN-1:0] quot_q, rem_q;

  mw_div_pre #(.XLEN(XLEN), .CW(CW)) u_pre (
    .size_i     (size_e'(size_i)),
    .mode64_i   (mode64_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .hi_o       (hi),
    .lo_o       (lo),
    .dv_o       (dv),
    .steps_o    (steps),
    .err_o      (pre_err)
  );

  assign accept = start_i && !busy;

  mw_div_core #(.XLEN(XLEN), .CW(CW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept && !pre_err),
    .hi_i      (hi),
    .lo_i      (lo),
    .dv_i      (dv),
    .steps_i   (steps),
    .busy_o    (busy),
    .last_o    (last),
    .quo_nxt_o (quo_nxt),
    .rem_nxt_o (rem_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      quot_q <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept && pre_err) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (last) begin
        done_q <= 1'b1;
        quot_q <= quo_nxt;
        rem_q  <= rem_nxt;
      end
    end
  end

  assign busy_o = busy;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  p_err_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> ($stable(quot_o) && $stable(rem_o)));
  p_zero_div_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> (done_o && err_o));
  p_reject_q_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && size_i == SZ_Q && !mode64_i) |=> (done_o && err_o));
  p_no_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || (done_o && !err_o)));
endmodule

// File: tb/sim_mw_div.sv
module sim_mw_div;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   size = '0;
  logic         m64 = 1'b0;
  logic [127:0] dd = '0;
  logic [63:0]  dv = '0;
  logic         busy, done, err;
  logic [63:0]  quot, rem;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
  logic [63:0] prev_q = '0, prev_r = '0;

  always #2 clk = ~clk;

  mw_div u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .mode64_i(m64),
    .dividend_i(dd), .divisor_i(dv), .busy_o(busy), .done_o(done), .err_o(err),
    .quot_o(quot), .rem_o(rem)
  );

  task automatic rnd(output logic [63:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    v = seed;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int s, input bit mm, input logic [127:0] d_in, input logic [63:0] v_in, input bit poke);
    int n = 8 << s;
    logic [127:0] m2 = (s == 3) ? '1 : ((128'd1 << (2 * n)) - 1);
    logic [127:0] m1 = (128'd1 << n) - 1;
    logic [127:0] ddm = d_in & m2;
    logic [127:0] dvm = {64'd0, v_in} & m1;
    logic [127:0] q = 0, r = 0;
    bit exp_err;
    string etag;
    int lat = 1;
    int exp_lat;
    if (s == 3 && !mm) begin exp_err = 1; etag = "R6"; end
    else if (dvm == 0) begin exp_err = 1; etag = "R3"; end
    else begin
      q = ddm / dvm;
      r = ddm % dvm;
      exp_err = (q > m1);
      etag = "R4";
    end
    exp_lat = exp_err ? 1 : n + 1;
    @(negedge clk);
    start = 1; size = s[1:0]; m64 = mm; dd = d_in; dv = v_in;
    @(negedge clk);
    start = 0;
    if (!exp_err) begin
      chk(busy === 1'b1, "R8 busy", {127'd0, busy}, 128'd1);
      if (poke) begin
        start = 1; dd = ~d_in; dv = 64'd0; size = 2'd0;
      end
    end
    while (!done && lat < 100) begin
      @(negedge clk);
      start = 0;
      lat++;
    end
    chk(lat == exp_lat, "R7 latency", lat, exp_lat);
    chk(err === exp_err, {etag, " err"}, {127'd0, err}, {127'd0, exp_err});
    if (exp_err) begin
      chk(quot === prev_q && rem === prev_r, {etag, " unchanged"}, {quot, rem}, {prev_q, prev_r});
    end else begin
      chk(quot === q[63:0] && rem === r[63:0], poke ? "R8 ignored start" : "R1/R2 result",
          {quot, rem}, {q[63:0], r[63:0]});
      chk({64'd0, rem} < dvm, "R5 rem<div", {64'd0, rem}, dvm);
      prev_q = q[63:0];
      prev_r = r[63:0];
    end
    @(negedge clk);
    chk(done === 1'b0, "R7 single pulse", {127'd0, done}, 128'd0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, b, c, g;
    logic [127:0] hi, lo, m1, ddv;
    logic [63:0] dvv;
    repeat (3) @(negedge clk);
    chk({busy, done, err} === 3'b000 && quot === '0 && rem === '0, "R9 reset",
        {busy, done, err, quot, rem}, 128'd0);
    rst_n = 1;
    // byte width: every divisor, several dividends each
    for (int d = 0; d < 256; d++) begin
      for (int k = 0; k < 6; k++) begin
        rnd(a); rnd(b); rnd(g);
        if (d == 0) hi = {120'd0, a[7:0]};
        else if (k == 5) hi = 128'(d) + 128'(a[15:0] % (256 - d));
        else if (k == 4) hi = 128'(d - 1);
        else hi = 128'(a[15:0] % d);
        ddv = {g, 48'd0, hi[7:0], b[7:0]};
        dvv = {b[63:8], 8'(d)};
        run(0, a[40], ddv, dvv, k == 2);
      end
    end
    // wider widths
    for (int s = 1; s < 4; s++) begin
      int n = 8 << s;
      m1 = (128'd1 << n) - 1;
      for (int k = 0; k < 200; k++) begin
        rnd(a); rnd(b); rnd(c); rnd(g);
        dvv = a >> (c[5:0] % n);
        if (k % 40 == 0) dvv = 64'd0;
        if (k % 40 == 5) dvv = 64'd1;
        if ((m1[63:0] & dvv) == 0 && k % 40 != 0) dvv = 64'd3;
        if (k % 40 == 1) hi = {64'd0, dvv} & m1;
        else if (k % 40 == 2) hi = ({64'd0, dvv} & m1) - 1;
        else if (k % 40 == 3) hi = {64'd0, b} & m1;
        else if ((m1[63:0] & dvv) != 0) hi = {64'd0, b % (m1[63:0] & dvv)};
        else hi = {64'd0, b} & m1;
        lo = (k % 40 == 2) ? m1 : ({64'd0, c} & m1);
        ddv = (s == 3) ? {hi[63:0], lo[63:0]}
                       : (({64'd0, g} << (2 * n)) | (hi << n) | lo);
        if (s < 3) dvv = dvv | ((a ^ g) << n);
        run(s, (s == 3) ? (k % 10 != 7) : g[3], ddv, dvv, k % 25 == 4);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule